// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block decides whether a phase-locked loop has settled. On each comparison cycle it times the gap, in ticks of a fast sample clock, between the rising edge of the divided reference clock and the rising edge of the divided feedback clock. Either edge may come first. It raises a lock flag only after a programmable run of consecutive cycles has shown a small error. Once the flag is set, it clears only when a single cycle shows an error above a second, larger threshold. The gap between the two thresholds gives the flag hysteresis.

The two divided clocks enter as plain levels and are synchronised to the sample clock inside the block. A precision select picks whether three or five good cycles are needed to lock. A power-down input returns the detector to its unlocked starting state. If one divided edge goes missing for a whole period, the block treats that cycle as a large error. The sample clock is the only clock.

Top module: `lockdet_top`

## Requirements
- R1: After `rst_n` is released, `lock_flag` is 0. The flag is active high.
- R2: With `prec_sel` = 0, `lock_flag` rises after the third consecutive comparison cycle whose error is below `LOCK_TICKS` (default 4).
- R3: With `prec_sel` = 1, five such consecutive cycles are needed, so three or four are not enough.
- R4: While the flag is clear, a cycle with an error of `LOCK_TICKS` or more resets the run of good cycles to zero.
- R5: While the flag is set, a cycle with an error of at most `UNLOCK_TICKS` (default 6) keeps it set. One cycle with a larger error clears it.
- R6: The error is the number of sample ticks from the first rising edge to the other rising edge, whichever of the two divided clocks leads. Coincident edges give an error of 0.
- R7: If the leading clock rises again before the other clock has risen, the cycle is scored as a large error and a new measurement starts from that edge.
- R8: While `pwr_down` is 1, `lock_flag` is 0 from the next sample clock onward. The run count and the measurement in progress are discarded, so a full new run is needed after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down; clears and holds the detector |
| prec_sel | input | 1 | 0: three good cycles to lock; 1: five |
| ref_div | input | 1 | Divided reference clock (level) |
| fb_div | input | 1 | Divided feedback clock (level) |
| lock_flag | output | 1 | Lock indication, active high |

## Verification
The checker assumes that both divided clocks stay high and low for several sample ticks and that only one measurement closes per comparison period. It therefore scores at most one error per period and never sees the leading clock's re-edge and the trailing edge in the same tick. The stimulus keeps every comparison period at 32 ticks with 16-tick high phases, and keeps edge offsets at or below 7 ticks. It changes `prec_sel` and `pwr_down` only between periods. Missing edges are produced by holding one clock low for a whole period, which keeps the re-edge well apart from the other clock's edge.

// File: rtl/lockdet_pkg.sv
// Shared types for the lock detector: measurement state and result record.
package lockdet_pkg;
    localparam int ERR_W = 8;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_WAIT = 1'b1
    } meas_state_t;

    typedef struct packed {
        logic             valid;
        logic             big;
        logic [ERR_W-1:0] err;
    } meas_res_t;
endpackage

// File: rtl/lockdet_edge.sv
// Synchronises one divided clock into the sample domain and flags its
// rising edge for one tick. Assumes the input stays at each level for
// more than one sample tick.
module lockdet_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [SYNC_STAGES:0] sh;

    // Shift the level through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], din};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/lockdet_meas.sv
// Times the gap between the first rising edge and the other clock's rising
// edge. Emits one result per closed measurement. A repeated leading edge or
// a saturated count gives a result marked big. Assumes at most one edge per
// input per tick.
module lockdet_meas
    import lockdet_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output meas_res_t res
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    meas_state_t      state;
    logic             lead_ref;
    logic [ERR_W-1:0] cnt;
    logic             other_rise;
    logic             same_rise;

    assign other_rise = lead_ref ? fb_rise  : ref_rise;
    assign same_rise  = lead_ref ? ref_rise : fb_rise;

    // Measurement state machine with a saturating tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state    <= MS_IDLE;
            lead_ref <= 1'b0;
            cnt      <= '0;
            res      <= '0;
        end else begin
            res.valid <= 1'b0;
            case (state)
                MS_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        res.valid <= 1'b1;
                        res.big   <= 1'b0;
                        res.err   <= '0;
                    end else if (ref_rise || fb_rise) begin
                        state    <= MS_WAIT;
                        lead_ref <= ref_rise;
                        cnt      <= ERR_W'(1);
                    end
                end
                MS_WAIT: begin
                    if (other_rise) begin
                        res.valid <= 1'b1;
                        res.big   <= 1'b0;
                        res.err   <= cnt;
                        state     <= MS_IDLE;
                    end else if (same_rise) begin
                        res.valid <= 1'b1;
                        res.big   <= 1'b1;
                        res.err   <= CNT_MAX;
                        cnt       <= ERR_W'(1);
                    end else if (cnt == CNT_MAX) begin
                        res.valid <= 1'b1;
                        res.big   <= 1'b1;
                        res.err   <= CNT_MAX;
                        state     <= MS_IDLE;
                    end else begin
                        cnt <= cnt + ERR_W'(1);
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lockdet_judge.sv
// Counts consecutive small-error results and applies lock/unlock hysteresis.
// Assumes results arrive as single-tick valid pulses.
module lockdet_judge
    import lockdet_pkg::*;
#(
    parameter int LOCK_TICKS   = 4,
    parameter int UNLOCK_TICKS = 6,
    parameter int RUN_LO       = 3,
    parameter int RUN_HI       = 5,
    parameter int RUN_W        = $clog2(RUN_HI + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             prec,
    input  meas_res_t        res,
    output logic             lock,
    output logic [RUN_W-1:0] run
);
    logic             small_err;
    logic             large_err;
    logic [RUN_W-1:0] need;

    assign small_err = !res.big && (res.err < ERR_W'(LOCK_TICKS));
    assign large_err = res.big || (res.err > ERR_W'(UNLOCK_TICKS));
    assign need      = prec ? RUN_W'(RUN_HI) : RUN_W'(RUN_LO);

    // Run counter and flag update on each scored cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lock <= 1'b0;
            run  <= '0;
        end else if (res.valid) begin
            if (!lock) begin
                if (small_err) begin
                    if ((run + RUN_W'(1)) >= need) begin
                        lock <= 1'b1;
                        run  <= '0;
                    end else begin
                        run <= run + RUN_W'(1);
                    end
                end else begin
                    run <= '0;
                end
            end else if (large_err) begin
                lock <= 1'b0;
                run  <= '0;
            end
        end
    end
endmodule

// File: rtl/lockdet_top.sv
// Digital lock detector: edge synchronisers, phase-gap timer and hysteresis
// judge. Assumes one sample clock that is much faster than the divided clocks.
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int LOCK_TICKS   = 4,
    parameter int UNLOCK_TICKS = 6,
    parameter int RUN_LO       = 3,
    parameter int RUN_HI       = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic prec_sel,
    input  logic ref_div,
    input  logic fb_div,
    output logic lock_flag
);
    localparam int RUN_W = $clog2(RUN_HI + 1);

    logic [1:0]       div_in;
    logic [1:0]       div_rise;
    meas_res_t        meas_res;
    logic             meas_valid;
    logic             meas_big;
    logic [ERR_W-1:0] meas_err;
    logic [RUN_W-1:0] run_cnt;

    assign div_in = {fb_div, ref_div};

    for (genvar g = 0; g < 2; g++) begin : g_edge
        lockdet_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (div_in[g]),
            .rise (div_rise[g])
        );
    end

    lockdet_meas u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_down),
        .ref_rise(div_rise[0]),
        .fb_rise (div_rise[1]),
        .res     (meas_res)
    );

    assign meas_valid = meas_res.valid;
    assign meas_big   = meas_res.big;
    assign meas_err   = meas_res.err;

    lockdet_judge #(
        .LOCK_TICKS  (LOCK_TICKS),
        .UNLOCK_TICKS(UNLOCK_TICKS),
        .RUN_LO      (RUN_LO),
        .RUN_HI      (RUN_HI),
        .RUN_W       (RUN_W)
    ) u_judge (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pwr_down),
        .prec (prec_sel),
        .res  (meas_res),
        .lock (lock_flag),
        .run  (run_cnt)
    );
endmodule

// File: rtl/lockdet_chk.sv
// Property checker for lockdet_top, attached by bind below.
module lockdet_chk #(
    parameter int LOCK_TICKS   = 4,
    parameter int UNLOCK_TICKS = 6,
    parameter int RUN_HI       = 5,
    parameter int RUN_W        = 3,
    parameter int ERR_W        = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_down,
    input logic             lock_flag,
    input logic             meas_valid,
    input logic             meas_big,
    input logic [ERR_W-1:0] meas_err,
    input logic [RUN_W-1:0] run_cnt
);
    logic small_res;
    logic large_res;
    assign small_res = meas_valid && !meas_big && (meas_err < ERR_W'(LOCK_TICKS));
    assign large_res = meas_valid && (meas_big || (meas_err > ERR_W'(UNLOCK_TICKS)));

    a_r8_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !lock_flag);

    a_r5_unlock_on_large: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && large_res && !pwr_down) |=> !lock_flag);

    a_r5_hold_without_result: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && !meas_valid && !pwr_down) |=> lock_flag);

    a_r2_rise_on_small: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(small_res));

    a_r4_restart_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_flag && meas_valid && !small_res && !pwr_down) |=> (run_cnt == '0));

    a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < RUN_W'(RUN_HI));
endmodule

bind lockdet_top lockdet_chk #(
    .LOCK_TICKS  (LOCK_TICKS),
    .UNLOCK_TICKS(UNLOCK_TICKS),
    .RUN_HI      (RUN_HI),
    .RUN_W       (RUN_W),
    .ERR_W       (lockdet_pkg::ERR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .lock_flag (lock_flag),
    .meas_valid(meas_valid),
    .meas_big  (meas_big),
    .meas_err  (meas_err),
    .run_cnt   (run_cnt)
);

// File: tb/lockdet_top_tb.sv
module lockdet_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic prec_sel = 1'b0;
    logic ref_div = 1'b0;
    logic fb_div = 1'b0;
    logic lock_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lockdet_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .prec_sel (prec_sel),
        .ref_div  (ref_div),
        .fb_div   (fb_div),
        .lock_flag(lock_flag)
    );

    // Vector fields: [9] prec, [8] fb leads, [7] trailing edge missing,
    // [6:1] offset in ticks, [0] expected flag after the period.
    localparam int NV = 23;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,6'd1,1'b0},  // R2 run 1
        {1'b0,1'b0,1'b0,6'd1,1'b0},  // R2 run 2
        {1'b0,1'b0,1'b0,6'd1,1'b1},  // R2 third -> lock
        {1'b0,1'b0,1'b0,6'd5,1'b1},  // R5 mid error holds
        {1'b0,1'b0,1'b0,6'd6,1'b1},  // R5 at unlock limit holds
        {1'b0,1'b0,1'b0,6'd7,1'b0},  // R5 above limit clears
        {1'b0,1'b0,1'b0,6'd3,1'b0},  // R4 run 1
        {1'b0,1'b0,1'b0,6'd3,1'b0},  // R4 run 2
        {1'b0,1'b0,1'b0,6'd4,1'b0},  // R4 at lock limit restarts
        {1'b0,1'b1,1'b0,6'd0,1'b0},  // R6 coincident run 1
        {1'b0,1'b0,1'b0,6'd0,1'b0},  // R6 run 2
        {1'b0,1'b0,1'b0,6'd0,1'b1},  // R6 run 3 -> lock
        {1'b0,1'b1,1'b0,6'd2,1'b1},  // R6 fb leads, small
        {1'b0,1'b1,1'b0,6'd7,1'b0},  // R6 fb leads by 7 clears
        {1'b0,1'b1,1'b0,6'd1,1'b0},
        {1'b0,1'b1,1'b0,6'd1,1'b0},
        {1'b0,1'b1,1'b0,6'd1,1'b1},  // R6 lock with fb leading
        {1'b0,1'b0,1'b1,6'd0,1'b1},  // R7 fb missing, not yet scored
        {1'b0,1'b0,1'b0,6'd1,1'b0},  // R7 re-edge scored large; run 1
        {1'b1,1'b0,1'b0,6'd1,1'b0},  // R3 run 2
        {1'b1,1'b0,1'b0,6'd1,1'b0},  // R3 run 3 not enough
        {1'b1,1'b0,1'b0,6'd1,1'b0},  // R3 run 4 not enough
        {1'b1,1'b0,1'b0,6'd1,1'b1}   // R3 fifth -> lock
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_flag=%0b expected %0b", req, act, exp);
        end
    endtask

    // One 32-tick comparison period; inputs change only at falling edges.
    task automatic run_period(input bit p, input bit fb_lead, input bit miss, input int dly);
        prec_sel = p;
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            if (c == 0) begin
                if (fb_lead) fb_div = 1'b1; else ref_div = 1'b1;
            end
            if (c == dly && !miss) begin
                if (fb_lead) ref_div = 1'b1; else fb_div = 1'b1;
            end
            if (c == 16) begin
                ref_div = 1'b0;
                fb_div  = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", lock_flag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            run_period(VEC[i][9], VEC[i][8], VEC[i][7], int'(VEC[i][6:1]));
            check($sformatf("vector %0d (R2/R3/R4/R5/R6/R7)", i), lock_flag, VEC[i][0]);
        end

        // R8: power-down clears a set flag and holds it clear.
        @(negedge clk);
        pwr_down = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 cleared", lock_flag, 1'b0);
        run_period(1'b0, 1'b0, 1'b0, 1);
        check("R8 held in power-down", lock_flag, 1'b0);
        pwr_down = 1'b0;
        run_period(1'b0, 1'b0, 1'b0, 1);
        run_period(1'b0, 1'b0, 1'b0, 1);
        check("R8 run restarted", lock_flag, 1'b0);
        run_period(1'b0, 1'b0, 1'b0, 1);
        check("R8 relock after three", lock_flag, 1'b1);

        // R1: a new reset returns the flag to 0.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset again", lock_flag, 1'b0);
        rst_n = 1'b1;
        run_period(1'b0, 1'b0, 1'b0, 2);
        check("R1 no lock from one cycle", lock_flag, 1'b0);

        finish_run();
    end
endmodule